// File: doc/BRIEF.md
# Quiz First-Responder Lockout Controller

This block decides which of eight contestants pressed a button first and then freezes that result for the rest of the round. Each contestant has one button line. A line rests high and goes low while its button is held. Every line is brought into the clock domain through two flops. The arbitration logic then looks at all eight synchronised samples together. The first sample that shows any press fixes the contestant number, which runs from 1 to 8. From that point the block is locked, and any later press does nothing.

The held number appears on a 4-bit output and on a seven-segment pattern, and a buzzer-enable output turns on in the same cycle. Two or more presses can land in the same synchronised sample. In that case the highest contestant number among them wins. A reset button, sampled as a synchronous active-low reset, ends the round. It clears the number to 0, turns off the buzzer and re-arms the inputs.

Top module: `quiz_lockout`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block becomes unlocked after that edge: `winner` = 0, `locked` = 0, `buzzer` = 0, and `seg` shows the digit 0.
- R2: Button `btn_n[i]` is active low and belongs to contestant i+1. A press that is stable before clock edge k sets `locked` high after edge k+2, and not earlier.
- R3: When a single contestant's press is captured, `winner` holds that contestant's number, from 1 to 8.
- R4: When several button lines show a press in the same synchronised sample, `winner` takes the highest contestant number among them.
- R5: While locked, and until the next reset, `locked` stays high and `winner` and `seg` do not change, whatever the buttons do.
- R6: `buzzer` turns on in the same cycle as `locked` and stays equal to `locked` in every cycle.
- R7: `seg` is active high with bit order {g,f,e,d,c,b,a}. The patterns are 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D, 7=7'h07, 8=7'h7F.
- R8: A reset that arrives in the same cycle as a press takes precedence. The block stays unlocked and shows 0.
- R9: `locked` is high exactly when `winner` is non-zero.
- R10: `winner` changes outside reset only on the cycle in which `locked` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low round reset (reset button) |
| btn_n | input | 8 | Contestant buttons, active low; bit i belongs to contestant i+1 |
| winner | output | 4 | Captured contestant number, 0 when nobody has answered |
| seg | output | 7 | Seven-segment pattern {g,f,e,d,c,b,a}, active high |
| buzzer | output | 1 | Buzzer enable, high while a winner is held |
| locked | output | 1 | High while a winner is held |

## Verification
Two events can fall in the same cycle. The first is priority resolution between several presses. The bench lowers several button lines at the same negative edge, so they reach the synchroniser output together, and it expects the highest number among them. The second is the clash between a round reset and a capture. The bench holds `rst_n` low across the edges where a synchronised press arrives, and it expects the block to stay unlocked and show 0 after the button is released. A scoreboard queue holds the expected winner for each armed press. That winner is compared with `winner` and `seg` when `locked` rises.

// File: rtl/quiz_pkg.sv
// quiz_pkg: shared sizes and the digit-to-segment function for the
// quiz lockout controller. Assumes at most 15 contestants so that a
// number fits the 4-bit display digit.
package quiz_pkg;

    localparam int unsigned NUM_PLAYERS = 8;
    localparam int unsigned NUM_W       = $clog2(NUM_PLAYERS + 1);
    localparam int unsigned SEG_W       = 7;

    // Segment pattern {g,f,e,d,c,b,a}, active high; blank outside 0..9.
    function automatic logic [SEG_W-1:0] digit_to_seg(input logic [3:0] d);
        logic [SEG_W-1:0] s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/quiz_sync.sv
// quiz_sync: two-flop synchroniser per bit for asynchronous button lines.
// Assumes the inputs idle high; the reset value is therefore all ones
// (no press), so a reset never produces a phantom press.
module quiz_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Two-stage capture of the raw lines, reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '1;
            stable_q <= '1;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;

endmodule

// File: rtl/quiz_prio.sv
// quiz_prio: turns a vector of active-high press requests into the
// number of the highest requesting contestant (bit i -> number i+1),
// or 0 when no request is present. Purely combinational.
module quiz_prio #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned OUT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] req,
    output logic [OUT_W-1:0] num,
    output logic             any
);

    // Scan upward so that the highest set bit is the last one written.
    always_comb begin
        num = '0;
        for (int i = 0; i < int'(WIDTH); i++) begin
            if (req[i]) num = OUT_W'(i + 1);
        end
    end

    // Any-request flag, formed independently of the encoder.
    assign any = |req;

    // R4: a reported number always belongs to a requesting line that has
    // no higher requesting neighbour.
    always_comb begin
        if (any) begin
            a_prio_top_r4: assert (num != '0 && req[num-1] &&
                                   ((req >> num) == '0))
                else $error("priority encoder picked a non-top request");
        end
    end

endmodule

// File: rtl/quiz_seg7.sv
// quiz_seg7: registered-free decoder from the held contestant number to
// an active-high seven-segment pattern ordered {g,f,e,d,c,b,a}.
// Assumes the number never exceeds 9; other codes blank the display.
module quiz_seg7 #(
    parameter int unsigned IN_W = 4
) (
    input  logic [IN_W-1:0]            digit,
    output logic [quiz_pkg::SEG_W-1:0] seg
);

    // Widen to the display digit and look up the pattern.
    always_comb begin
        seg = quiz_pkg::digit_to_seg(4'(digit));
    end

endmodule

// File: rtl/quiz_lockout.sv
// quiz_lockout: first-responder arbitration for a quiz round. Button
// lines are synchronised, resolved by priority in one cycle, and the
// first non-empty sample is captured and locked until rst_n (a
// synchronous active-low reset) ends the round. Reset beats a capture.
module quiz_lockout
    import quiz_pkg::*;
#(
    parameter int unsigned PLAYERS = NUM_PLAYERS,
    parameter int unsigned WIN_W   = $clog2(PLAYERS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PLAYERS-1:0] btn_n,
    output logic [WIN_W-1:0]   winner,
    output logic [SEG_W-1:0]   seg,
    output logic               buzzer,
    output logic               locked
);

    logic [PLAYERS-1:0] btn_sync_n;
    logic [PLAYERS-1:0] press_req;
    logic [WIN_W-1:0]   top_num;
    logic               any_press;
    logic               capture;
    logic [WIN_W-1:0]   winner_q;
    logic               locked_q;
    logic               buzzer_q;

    quiz_sync #(.WIDTH(PLAYERS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (btn_n),
        .sync_out (btn_sync_n)
    );

    // Convert the active-low synchronised lines into press requests.
    assign press_req = ~btn_sync_n;

    quiz_prio #(.WIDTH(PLAYERS), .OUT_W(WIN_W)) u_prio (
        .req (press_req),
        .num (top_num),
        .any (any_press)
    );

    // A capture happens only while armed and only if someone pressed.
    assign capture = any_press && !locked_q;

    // Hold the winning number; written only on the capture cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       winner_q <= '0;
        else if (capture) winner_q <= top_num;
    end

    // Lock flag: set by a capture, cleared only by the round reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       locked_q <= 1'b0;
        else if (capture) locked_q <= 1'b1;
    end

    // Buzzer enable, kept in its own flop so it can be driven separately.
    always_ff @(posedge clk) begin
        if (!rst_n)       buzzer_q <= 1'b0;
        else if (any_press) buzzer_q <= 1'b1;
    end

    quiz_seg7 #(.IN_W(WIN_W)) u_seg (
        .digit (winner_q),
        .seg   (seg)
    );

    assign winner = winner_q;
    assign locked = locked_q;
    assign buzzer = buzzer_q;

    // R1: one cycle after a reset edge the block is unlocked and blank.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (winner_q == '0 && !locked_q && !buzzer_q));

    // R5: once locked, the lock and the number persist until reset.
    p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> (locked_q && $stable(winner_q)));

    // R6: the buzzer follows the lock in every cycle.
    p_buzz_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buzzer_q == locked_q);

    // R9: locked exactly when a non-zero number is held.
    p_lock_num_r9: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q == (winner_q != '0));

    // R10: the number moves only on the rising edge of the lock.
    p_num_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && winner_q != $past(winner_q)) |-> $rose(locked_q));

    // R3: the held number is always a valid contestant number or 0.
    p_num_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        winner_q <= WIN_W'(PLAYERS));

endmodule

// File: tb/tb_quiz_lockout.sv
// tb_quiz_lockout: scoreboard bench. Driver tasks push the expected
// winner into a queue; a monitor pops it when locked rises and compares.
module tb_quiz_lockout;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] btn_n = 8'hFF;
    logic [3:0] winner;
    logic [6:0] seg;
    logic       buzzer;
    logic       locked;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic prev_locked = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    quiz_lockout dut (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n),
        .winner(winner), .seg(seg), .buzzer(buzzer), .locked(locked)
    );

    function automatic logic [6:0] exp_seg(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B;
            3: return 7'h4F; 4: return 7'h66; 5: return 7'h6D;
            6: return 7'h7D; 7: return 7'h07; 8: return 7'h7F;
            default: return 7'h00;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Press the buttons in mask (bit i = contestant i+1) at a negedge
    // and queue the expected winner: the highest set bit.
    task automatic press(input logic [7:0] mask);
        int top = 0;
        for (int i = 0; i < 8; i++) if (mask[i]) top = i + 1;
        @(negedge clk);
        btn_n = ~mask;
        exp_q.push_back(top);
    endtask

    task automatic release_all();
        @(negedge clk);
        btn_n = 8'hFF;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: on the lock edge pop the expected winner and compare.
    always @(negedge clk) begin
        if (rst_n && locked && !prev_locked) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected capture", winner, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check("R3/R4 winner", winner, e);
                check("R7 seg", seg, exp_seg(e));
                check("R6 buzzer on with lock", buzzer, 1);
            end
        end
        prev_locked = locked;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        // R1: reset state
        check("R1 winner", winner, 0);
        check("R1 locked", locked, 0);
        check("R1 buzzer", buzzer, 0);
        check("R1 seg", seg, 7'h3F);
        rst_n = 1'b1;
        wait_cyc(2);

        // R2: latency of two sync flops plus capture
        press(8'b0000_0100);
        @(posedge clk); @(posedge clk); #1;
        check("R2 not yet locked", locked, 0);
        @(posedge clk); #1;
        check("R2 locked after third edge", locked, 1);
        wait_cyc(2);
        // R5: later press ignored
        @(negedge clk); btn_n = 8'h7F;
        wait_cyc(5);
        check("R5 winner held", winner, 3);
        check("R5 seg held", seg, exp_seg(3));
        check("R5 still locked", locked, 1);
        check("R9 lock vs number", locked, winner != 0);
        release_all();
        do_reset();
        check("R1 cleared by reset", winner, 0);
        check("R6 buzzer off after reset", buzzer, 0);

        // R3/R7: every contestant alone
        for (int k = 0; k < 8; k++) begin
            press(8'(1 << k));
            wait_cyc(4);
            release_all();
            do_reset();
        end

        // R4: simultaneous presses
        press(8'b0101_0010);
        wait_cyc(4); release_all(); do_reset();
        press(8'b1111_1111);
        wait_cyc(4); release_all(); do_reset();

        // R8: reset held while a press reaches the arbiter
        @(negedge clk);
        rst_n = 1'b0;
        btn_n = 8'b1110_1111;
        wait_cyc(4);
        btn_n = 8'hFF;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R8 reset wins over press", locked, 0);
        check("R8 display 0", seg, 7'h3F);

        check("R3 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule